// File: doc/BRIEF.md
# I2C Byte Master Transmitter with Flag Handshake

This block is a byte-level I2C master transmitter that software steers one bus step at a time. Software writes a byte register and a control register. A control write whose flag bit is zero clears the event flag and launches one step: a START condition, the transmission of one byte followed by its acknowledge clock, or a STOP condition. The engine drives the open-drain SCL and SDA lines through output enables (an enable of 1 pulls the line low) and reads the acknowledge from the wired-AND SDA level.

When a START or a byte step completes, the engine raises the event flag and posts a status code. After a byte, that code records whether the receiver pulled SDA low on the ninth clock. While the flag is set, the engine holds SCL low, which stretches the bus, and starts nothing new. A STOP step ends with both lines released, the status back at idle and the flag left clear. Bit timing comes from a run-time divider input: every bit has four phases, and each phase lasts `clk_div + 1` system clocks (`clk_div` must be at least 1).

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the flag is 0, the status reads 0xF8, and both output enables are 0 (lines released).
- R2: The control register is write address 0 and the data register is write address 1. In the control byte, bits [1:0] select the command (01 START, 10 send byte, 11 STOP, 00 none) and bit 7 is the flag bit. A START makes SDA fall while SCL is high and then pulls SCL low. It then sets the flag with status 0x08.
- R3: A byte is shifted out MSB first. SDA changes only while SCL is low. The ninth clock is given with SDA released.
- R4: The first byte after a START is the address byte. It completes with status 0x18 when the receiver holds SDA low on the ninth clock (ACK) and with status 0x20 otherwise (NACK).
- R5: Every later byte completes with status 0x28 on ACK and 0x30 on NACK.
- R6: While the flag is set, SCL is pulled low.
- R7: While the flag is set, a control write whose bit 7 is 1 leaves the flag, the status and both lines unchanged, whatever command it carries.
- R8: A control write with bit 7 equal to 0 that the engine accepts clears the flag. The selected step begins on that same clock edge.
- R9: The byte shifted out is the value held in the data register when the step is launched. Writes to the data register during the transfer do not alter it.
- R10: STOP makes SDA rise while SCL is high and leaves both lines released. The status returns to 0xF8 and the flag stays clear.
- R11: Each bit phase lasts clk_div+1 clocks. The flag is set 4*(clk_div+1) clocks after a START launch and 36*(clk_div+1) clocks after a byte launch. A control write arriving during a step, including the cycle in which that step completes, is ignored.
- R12: Send-byte and STOP commands are ignored while the bus is idle, that is, before a START or after a STOP.
- R13: A START issued while the flag is held after a byte produces a repeated START with status 0x08. The next byte is again treated as an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 the data register |
| wr_data | input | 8 | Write value |
| clk_div | input | DIV_W | Phase length minus one, in system clocks |
| sda_in | input | 1 | Sampled wired-AND level of SDA |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq_flag | output | 1 | Event flag, set when a START or byte step completes |
| status | output | 8 | Status code of the last event |

## Verification
Two things can fall on the same clock edge: a bus step completing and raising the flag, and a software control write that would clear the flag and launch a new command. The bench computes the completion edge from the current divider value, 36*(clk_div+1) clocks after the launch. It drives a flag-clearing STOP command so that this write is sampled on exactly that edge. The outcome is judged at the ports. The flag must read 1 immediately afterwards, SCL must stay held low, and the bus monitor must see no STOP. The same transfer also carries a data-register write and a stray START command partway through, to show that the launched byte and the running step are untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   localparam int BYTE_W    = 8;
   localparam int FRAME_LEN = BYTE_W + 1;
   localparam int BIT_IDX_W = $clog2(FRAME_LEN);

   localparam int CTRL_FLAG_BIT = 7;
   localparam logic ADDR_CTRL   = 1'b0;
   localparam logic ADDR_DATA   = 1'b1;

   localparam logic [BYTE_W-1:0] ST_START     = 8'h08;
   localparam logic [BYTE_W-1:0] ST_ADDR_ACK  = 8'h18;
   localparam logic [BYTE_W-1:0] ST_ADDR_NACK = 8'h20;
   localparam logic [BYTE_W-1:0] ST_DATA_ACK  = 8'h28;
   localparam logic [BYTE_W-1:0] ST_DATA_NACK = 8'h30;
   localparam logic [BYTE_W-1:0] ST_IDLE      = 8'hF8;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'b00,
      CMD_START = 2'b01,
      CMD_SEND  = 2'b10,
      CMD_STOP  = 2'b11
   } cmd_e;

   typedef enum logic [1:0] {
      EV_NONE,
      EV_START,
      EV_BYTE,
      EV_STOP
   } evt_e;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || cnt_q == div) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == div);
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q <= {chain_q[STAGES-2+1-1:0], d} >> 0;
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
   import i2cm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  cmd_e              cmd,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              sda_in,
   output logic              busy,
   output logic              owned,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              ev_fire,
   output evt_e              ev_kind,
   output logic              ev_ack
);
   typedef enum logic [2:0] {
      S_IDLE,
      S_HOLD,
      S_START,
      S_BITS,
      S_STOP
   } state_e;

   localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_LEN - 1);

   state_e                 state_q;
   logic [1:0]             phase_q;
   logic [BIT_IDX_W-1:0]   bit_q;
   logic [FRAME_LEN-1:0]   shift_q;
   logic                   ack_q;

   assign busy  = (state_q == S_START) || (state_q == S_BITS) || (state_q == S_STOP);
   assign owned = (state_q == S_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         phase_q <= 2'd0;
         bit_q   <= '0;
         shift_q <= '0;
         ack_q   <= 1'b0;
         scl_oe  <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (launch) begin
         phase_q <= 2'd0;
         case (cmd)
            CMD_START: begin
               state_q <= S_START;
               sda_oe  <= 1'b0;
            end
            CMD_SEND: begin
               state_q <= S_BITS;
               bit_q   <= '0;
               shift_q <= {tx_byte, 1'b1};
               scl_oe  <= 1'b1;
               sda_oe  <= ~tx_byte[BYTE_W-1];
            end
            CMD_STOP: begin
               state_q <= S_STOP;
               scl_oe  <= 1'b1;
               sda_oe  <= 1'b1;
            end
            default: ;
         endcase
      end else if (tick && busy) begin
         phase_q <= phase_q + 2'd1;
         case (state_q)
            S_START: begin
               case (phase_q)
                  2'd0: scl_oe <= 1'b0;
                  2'd1: sda_oe <= 1'b1;
                  2'd2: scl_oe <= 1'b1;
                  default: state_q <= S_HOLD;
               endcase
            end
            S_BITS: begin
               case (phase_q)
                  2'd0: scl_oe <= 1'b0;
                  2'd1: ;
                  2'd2: begin
                     scl_oe <= 1'b1;
                     if (bit_q == LAST_BIT) ack_q <= ~sda_in;
                  end
                  default: begin
                     if (bit_q == LAST_BIT) begin
                        state_q <= S_HOLD;
                     end else begin
                        bit_q   <= bit_q + 1'b1;
                        shift_q <= {shift_q[FRAME_LEN-2:0], 1'b1};
                        sda_oe  <= ~shift_q[FRAME_LEN-2];
                     end
                  end
               endcase
            end
            S_STOP: begin
               case (phase_q)
                  2'd0: scl_oe <= 1'b0;
                  2'd1: sda_oe <= 1'b0;
                  2'd2: ;
                  default: state_q <= S_IDLE;
               endcase
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      ev_fire = tick && busy && (phase_q == 2'd3) &&
                ((state_q != S_BITS) || (bit_q == LAST_BIT));
      ev_ack  = ack_q;
      case (state_q)
         S_START: ev_kind = EV_START;
         S_BITS:  ev_kind = EV_BYTE;
         S_STOP:  ev_kind = EV_STOP;
         default: ev_kind = EV_NONE;
      endcase
   end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
   import i2cm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              busy,
   input  logic              owned,
   input  logic              ev_fire,
   input  evt_e              ev_kind,
   input  logic              ev_ack,
   output logic              launch,
   output cmd_e              cmd,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              flag,
   output logic [BYTE_W-1:0] status
);
   logic [BYTE_W-1:0] data_q;
   logic              addr_next_q;
   logic              ctrl_clear;
   logic              cmd_legal;

   assign cmd        = cmd_e'(wr_data[1:0]);
   assign ctrl_clear = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[CTRL_FLAG_BIT];

   always_comb begin
      case (cmd)
         CMD_START: cmd_legal = !busy;
         CMD_SEND:  cmd_legal = owned;
         CMD_STOP:  cmd_legal = owned;
         default:   cmd_legal = 1'b0;
      endcase
   end

   assign launch  = ctrl_clear && cmd_legal;
   assign tx_byte = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (wr_en && (wr_addr == ADDR_DATA)) begin
         data_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag        <= 1'b0;
         status      <= ST_IDLE;
         addr_next_q <= 1'b0;
      end else if (ev_fire) begin
         case (ev_kind)
            EV_START: begin
               flag        <= 1'b1;
               status      <= ST_START;
               addr_next_q <= 1'b1;
            end
            EV_BYTE: begin
               flag        <= 1'b1;
               addr_next_q <= 1'b0;
               if (addr_next_q) status <= ev_ack ? ST_ADDR_ACK : ST_ADDR_NACK;
               else             status <= ev_ack ? ST_DATA_ACK : ST_DATA_NACK;
            end
            EV_STOP: begin
               status      <= ST_IDLE;
               addr_next_q <= 1'b0;
            end
            default: ;
         endcase
      end else if (ctrl_clear && !busy) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cm_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              irq_flag,
   output logic [BYTE_W-1:0] status
);
   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
         $error("i2c_byte_master: DIV_W must lie in 2..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("i2c_byte_master: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic              seq_busy;
   logic              seq_owned;
   logic              tick;
   logic              sda_s;
   logic              launch;
   cmd_e              cmd;
   logic [BYTE_W-1:0] tx_byte;
   logic              ev_fire;
   evt_e              ev_kind;
   logic              ev_ack;

   i2cm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(seq_busy), .div(clk_div), .tick(tick)
   );

   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   i2cm_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(seq_busy), .owned(seq_owned),
      .ev_fire(ev_fire), .ev_kind(ev_kind), .ev_ack(ev_ack),
      .launch(launch), .cmd(cmd), .tx_byte(tx_byte),
      .flag(irq_flag), .status(status)
   );

   i2cm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd),
      .tx_byte(tx_byte), .tick(tick), .sda_in(sda_s),
      .busy(seq_busy), .owned(seq_owned), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .ev_fire(ev_fire), .ev_kind(ev_kind), .ev_ack(ev_ack)
   );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
   import i2cm_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [BYTE_W-1:0] wr_data,
   input logic              flag,
   input logic [BYTE_W-1:0] status,
   input logic              scl_oe,
   input logic              sda_oe,
   input logic              busy
);
   logic clear_wr;
   assign clear_wr = wr_en && (wr_addr == ADDR_CTRL) && !wr_data[CTRL_FLAG_BIT];

   a_r6_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
      flag |-> scl_oe);

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clear_wr) |=> (flag && $stable(scl_oe) && $stable(sda_oe) && $stable(status)));

   a_r8_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_wr && !busy) |=> !flag);

   a_r11_flag_from_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(busy));

   a_r10_stop_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && status == ST_IDLE) |-> !flag);

   a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !flag && status == ST_IDLE) |-> (!scl_oe && !sda_oe));

   a_r1_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
      (status == ST_IDLE || status == ST_START || status == ST_ADDR_ACK ||
       status == ST_ADDR_NACK || status == ST_DATA_ACK || status == ST_DATA_NACK));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .flag(irq_flag), .status(status),
   .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(seq_busy)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] clk_div = 8'd3;
   logic       scl_oe, sda_oe, irq_flag;
   logic [7:0] status;
   logic       slave_pull = 1'b0;
   logic       sda_bus;

   int n_chk = 0;
   int n_fail = 0;
   bit ack_plan = 1'b1;
   int start_cnt = 0, stop_cnt = 0, byte_cnt = 0, bitcnt = 0;
   logic [7:0] shin = 8'h00, last_byte = 8'h00;
   logic scl_p = 1'b1, sda_p = 1'b1;

   always #4 clk = ~clk;

   assign sda_bus = ~(sda_oe | slave_pull);

   i2c_byte_master dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clk_div(clk_div), .sda_in(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq_flag(irq_flag), .status(status)
   );

   // Receiver model: watches bus conditions, collects bits, acknowledges per ack_plan.
   always @(posedge clk) begin
      if (!scl_oe && scl_p && sda_p && !sda_bus) begin
         start_cnt++;
         bitcnt = 0;
      end else if (!scl_oe && scl_p && !sda_p && sda_bus) begin
         stop_cnt++;
      end
      if (!scl_oe && !scl_p) begin
         if (bitcnt < 8) shin = {shin[6:0], sda_bus};
         bitcnt++;
         if (bitcnt == 8) begin
            last_byte = shin;
            byte_cnt++;
         end
      end
      if (scl_oe && scl_p) begin
         if (bitcnt == 8) slave_pull <= ack_plan;
         else if (bitcnt == 9) begin
            slave_pull <= 1'b0;
            bitcnt = 0;
         end
      end
      scl_p <= !scl_oe;
      sda_p <= sda_bus;
   end

   function automatic logic [7:0] exp_byte_status(input bit first, input bit ack);
      if (first) return ack ? 8'h18 : 8'h20;
      return ack ? 8'h28 : 8'h30;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_flag(input string req);
      int cyc = 0;
      while (!irq_flag && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(irq_flag, req, irq_flag, 1);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit ack, input bit first);
      ack_plan = ack;
      wr(1'b1, b);
      wr(1'b0, 8'h02);
      chk(irq_flag == 1'b0, "R8 flag cleared by send", irq_flag, 0);
      wait_flag("R11 byte completes");
      chk(last_byte == b, "R3 MSB-first byte on bus", last_byte, b);
      chk(status == exp_byte_status(first, ack), first ? "R4 address status" : "R5 data status",
          status, exp_byte_status(first, ack));
      chk(scl_oe == 1'b1, "R6 SCL held after byte", scl_oe, 1);
   endtask

   task automatic do_stop();
      int s0 = stop_cnt;
      wr(1'b0, 8'h03);
      repeat (4 * (clk_div + 1) + 6) @(negedge clk);
      chk(stop_cnt == s0 + 1, "R10 STOP seen on bus", stop_cnt, s0 + 1);
      chk(irq_flag == 1'b0, "R10 no flag after STOP", irq_flag, 0);
      chk(status == 8'hF8, "R10 status idle", status, 8'hF8);
      chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int k;
      int s0;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(irq_flag == 1'b0, "R1 flag after reset", irq_flag, 0);
      chk(status == 8'hF8, "R1 status after reset", status, 8'hF8);
      chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

      // R12 send and stop while idle are ignored
      wr(1'b1, 8'hA5);
      wr(1'b0, 8'h02);
      wr(1'b0, 8'h03);
      repeat (40) @(negedge clk);
      chk(!scl_oe && !sda_oe && irq_flag == 1'b0, "R12 idle ignores send/stop",
          {scl_oe, sda_oe, irq_flag}, 0);
      chk(status == 8'hF8 && byte_cnt == 0, "R12 no bus activity", byte_cnt, 0);

      // R2/R11 START timing, clk_div = 3
      clk_div = 8'd3;
      k = 4 * (clk_div + 1);
      wr(1'b0, 8'h01);
      for (int m = 1; m <= k; m++) begin
         @(negedge clk);
         if (m == k - 1) chk(irq_flag == 1'b0, "R11 START not done early", irq_flag, 0);
      end
      chk(irq_flag == 1'b1, "R11 START done on time", irq_flag, 1);
      chk(status == 8'h08, "R2 START status", status, 8'h08);
      chk(start_cnt == 1, "R2 START condition on bus", start_cnt, 1);
      chk(scl_oe && sda_oe, "R2 both lines low after START", {scl_oe, sda_oe}, 3);

      // R7 command with flag bit set is ignored
      wr(1'b0, 8'h82);
      wr(1'b0, 8'h83);
      repeat (40) @(negedge clk);
      chk(irq_flag == 1'b1 && status == 8'h08, "R7 flag and status unchanged", status, 8'h08);
      chk(scl_oe && sda_oe && byte_cnt == 0, "R7 lines unchanged", {scl_oe, sda_oe}, 3);

      // R9/R11 address byte with mid-transfer writes and a clearing write on the completion edge
      ack_plan = 1'b1;
      wr(1'b1, 8'hA4);
      wr(1'b0, 8'h02);
      k = 36 * (clk_div + 1);
      s0 = stop_cnt;
      for (int m = 1; m <= k; m++) begin
         @(negedge clk);
         if (m == 10) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h5B; end
         if (m == 11) wr_en = 1'b0;
         if (m == 40) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h01; end
         if (m == 41) wr_en = 1'b0;
         if (m == k - 1) begin
            chk(irq_flag == 1'b0, "R11 byte not done early", irq_flag, 0);
            wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h03;
         end
      end
      wr_en = 1'b0;
      chk(irq_flag == 1'b1, "R11 flag set despite same-edge clear", irq_flag, 1);
      chk(last_byte == 8'hA4, "R9 launched byte shifted", last_byte, 8'hA4);
      chk(status == 8'h18, "R4 address ACK status", status, 8'h18);
      chk(start_cnt == 1, "R11 stray START ignored", start_cnt, 1);
      repeat (30) @(negedge clk);
      chk(scl_oe == 1'b1 && stop_cnt == s0, "R6 bus held, no STOP", stop_cnt, s0);

      // R5 data bytes: NACK then ACK (data register now holds 0x5B from the late write)
      send_byte(8'h3C, 1'b0, 1'b0);
      send_byte(8'h81, 1'b1, 1'b0);

      // R13 repeated START then address NACK
      wr(1'b0, 8'h01);
      wait_flag("R13 repeated START done");
      chk(status == 8'h08 && start_cnt == 2, "R13 repeated START", start_cnt, 2);
      send_byte(8'h7E, 1'b0, 1'b1);

      do_stop();

      // R12 STOP after STOP ignored
      wr(1'b0, 8'h03);
      repeat (30) @(negedge clk);
      chk(!scl_oe && !sda_oe && status == 8'hF8, "R12 STOP while idle ignored", status, 8'hF8);

      // Random transactions
      for (int t = 0; t < 6; t++) begin
         int nd;
         clk_div = 8'(1 + ($urandom % 5));
         wr(1'b0, 8'h01);
         wait_flag("R2 random START");
         chk(status == 8'h08, "R2 random START status", status, 8'h08);
         send_byte(8'($urandom), 1'($urandom), 1'b1);
         nd = 1 + ($urandom % 3);
         for (int d = 0; d < nd; d++) send_byte(8'($urandom), 1'($urandom), 1'b0);
         do_stop();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule